// File: doc/BRIEF.md
# Load/Store Address Sequencer

This block carries out the memory-access class of a 16-bit load/store instruction set. A surrounding core hands it an instruction word and the already-incremented program counter, pulses `start`, and waits for `done`. The sequencer reads up to two registers through combinational read ports and forms an effective address in one of two ways: the program counter plus a sign-extended 9-bit offset, or a base register plus a sign-extended 6-bit offset. It then runs zero, one or two transactions on a simple request/ready memory port. It finishes by writing a register or storing a word.

Indirect forms first fetch a pointer from the program-counter-relative address and then use that pointer as the address of the real access. The address-only form copies the computed address into the destination register and never touches memory. Every register write also updates a three-bit condition code with exactly one of negative, zero or positive set. Stores leave the condition code alone.

The controller has six states:
- IDLE waits for `start`.
- ADDR latches the effective address.
- IND_READ fetches the pointer.
- ACCESS performs the final read or write.
- WRITEBACK writes the register file and the condition code.
- DONE raises `done` for one cycle.

It moves between them as follows:
- IDLE→ADDR when `start` arrives with a supported opcode.
- ADDR→WRITEBACK for the address-only form.
- ADDR→IND_READ for indirect forms.
- ADDR→ACCESS otherwise.
- IND_READ→ACCESS on `mem_ready`.
- ACCESS→WRITEBACK on `mem_ready` for loads.
- ACCESS→DONE on `mem_ready` for stores.
- WRITEBACK→DONE unconditionally.
- DONE→IDLE unconditionally.

Top module: `lsag_seq`

## Requirements
- R1: After reset the block is idle. `mem_req`, `mem_we`, `rf_we`, `busy` and `done` are all low, and `cc` reads 3'b010 (zero).
- R2: Opcode 4'b0010 (direct load) reads memory once at `pc_next` + sext(instr[8:0]). It writes the returned word to the register named by instr[11:9]. With a memory that answers without wait states, `done` is high on the fourth cycle after `start` is taken.
- R3: Opcode 4'b0011 (direct store) writes the register named by instr[11:9] to `pc_next` + sext(instr[8:0]). It makes exactly one memory write and no register write.
- R4: Opcode 4'b1010 (indirect load) reads a pointer at `pc_next` + sext(instr[8:0]). It then reads at that pointer and writes the second word to the register named by instr[11:9]. This takes exactly two reads.
- R5: Opcode 4'b1011 (indirect store) reads a pointer at `pc_next` + sext(instr[8:0]). It then writes the register named by instr[11:9] to that pointer. This takes one read and one write, and `mem_we` is only ever high together with `mem_req`.
- R6: Opcodes 4'b0110 (base load) and 4'b0111 (base store) use the address base register instr[8:6] + sext(instr[5:0]). Their data register is instr[11:9].
- R7: Opcode 4'b1110 (address-only) writes `pc_next` + sext(instr[8:0]) to the register named by instr[11:9]. It never raises `mem_req`, and `done` is high on the third cycle after `start`.
- R8: Every register write sets `cc` to exactly one of the following, based on the written value:
  - N = bit 2 when bit 15 is set.
  - Z = bit 1 when the value is zero.
  - P = bit 0 otherwise.

  Stores leave `cc` unchanged.
- R9: While `mem_req` is high and `mem_ready` is low, the request, address and write enable hold steady. A transaction completes only on a cycle with both high.
- R10: All address sums wrap modulo 2^16.
- R11: `done` is a single-cycle pulse. `start` is ignored while `busy` is high. A `start` carrying any other opcode is ignored, with no memory access and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the instruction on `instr` (taken only when idle) |
| instr | input | 16 | Instruction word |
| pc_next | input | 16 | Address of the instruction plus one |
| rf_src_idx | output | 3 | Register index for store data / destination |
| rf_src_data | input | 16 | Register file read data for `rf_src_idx` |
| rf_base_idx | output | 3 | Register index for the base register |
| rf_base_data | input | 16 | Register file read data for `rf_base_idx` |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 16 | Register write data |
| mem_req | output | 1 | Memory request, held until `mem_ready` |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the current transaction |
| cc | output | 3 | Condition code {N, Z, P} |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state or a wrong branch out of ADDR shows at the memory port within one cycle of the decision. It appears as an extra or missing request, a read where a write belongs, or a request during the address-only form. A wrongly latched address or pointer appears on `mem_addr` in the very next access, or on `rf_wdata` one cycle before `done`. Counting handshakes per instruction, checking the stored register contents and `cc` after each `done`, and timing `done` against `start` therefore expose most internal faults within the same instruction.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
    localparam int WORD_W  = 16;
    localparam int REG_N   = 8;
    localparam int RIDX_W  = $clog2(REG_N);
    localparam int OP_W    = 4;
    localparam int PCOFF_W = 9;
    localparam int BOFF_W  = 6;

    localparam logic [OP_W-1:0] OPC_LOAD    = 4'b0010;
    localparam logic [OP_W-1:0] OPC_STORE   = 4'b0011;
    localparam logic [OP_W-1:0] OPC_LOAD_B  = 4'b0110;
    localparam logic [OP_W-1:0] OPC_STORE_B = 4'b0111;
    localparam logic [OP_W-1:0] OPC_LOAD_I  = 4'b1010;
    localparam logic [OP_W-1:0] OPC_STORE_I = 4'b1011;
    localparam logic [OP_W-1:0] OPC_ADDR    = 4'b1110;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_IND_READ,
        S_ACCESS,
        S_WRITEBACK,
        S_DONE
    } state_e;

    typedef struct packed {
        logic legal;
        logic store;
        logic indirect;
        logic base_mode;
        logic addr_only;
    } ctl_t;
endpackage

// File: rtl/lsag_decode.sv
module lsag_decode
    import lsag_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctl_t            ctl
);
    always_comb begin
        ctl = '0;
        case (opcode)
            OPC_LOAD: begin
                ctl.legal = 1'b1;
            end
            OPC_STORE: begin
                ctl.legal = 1'b1;
                ctl.store = 1'b1;
            end
            OPC_LOAD_B: begin
                ctl.legal     = 1'b1;
                ctl.base_mode = 1'b1;
            end
            OPC_STORE_B: begin
                ctl.legal     = 1'b1;
                ctl.store     = 1'b1;
                ctl.base_mode = 1'b1;
            end
            OPC_LOAD_I: begin
                ctl.legal    = 1'b1;
                ctl.indirect = 1'b1;
            end
            OPC_STORE_I: begin
                ctl.legal    = 1'b1;
                ctl.store    = 1'b1;
                ctl.indirect = 1'b1;
            end
            OPC_ADDR: begin
                ctl.legal     = 1'b1;
                ctl.addr_only = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/lsag_agen.sv
module lsag_agen #(
    parameter int W       = 16,
    parameter int PCOFF_W = 9,
    parameter int BOFF_W  = 6
) (
    input  logic [PCOFF_W-1:0] off_field,
    input  logic [W-1:0]       pc,
    input  logic [W-1:0]       base,
    input  logic               base_mode,
    output logic [W-1:0]       ea
);
    localparam int PC_PAD = W - PCOFF_W;
    localparam int B_PAD  = W - BOFF_W;

    logic [W-1:0] pc_off;
    logic [W-1:0] base_off;

    assign pc_off   = {{PC_PAD{off_field[PCOFF_W-1]}}, off_field};
    assign base_off = {{B_PAD{off_field[BOFF_W-1]}}, off_field[BOFF_W-1:0]};

    // Sums are W bits wide, so they wrap modulo 2^W.
    always_comb begin
        if (base_mode) begin
            ea = base + base_off;
        end else begin
            ea = pc + pc_off;
        end
    end
endmodule

// File: rtl/lsag_cc.sv
module lsag_cc #(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    output logic [2:0]   nzp
);
    always_comb begin
        if (value[W-1]) begin
            nzp = 3'b100;
        end else if (value == '0) begin
            nzp = 3'b010;
        end else begin
            nzp = 3'b001;
        end
    end
endmodule

// File: rtl/lsag_seq.sv
module lsag_seq
    import lsag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] pc_next,
    output logic [RIDX_W-1:0] rf_src_idx,
    input  logic [WORD_W-1:0] rf_src_data,
    output logic [RIDX_W-1:0] rf_base_idx,
    input  logic [WORD_W-1:0] rf_base_data,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [2:0]        cc,
    output logic              busy,
    output logic              done
);
    localparam int OP_LSB   = WORD_W - OP_W;
    localparam int REG_LSB  = OP_LSB - RIDX_W;
    localparam int BASE_LSB = REG_LSB - RIDX_W;

    state_e            state_q, state_d;
    ctl_t              ctl_new, ctl_q;
    logic [WORD_W-1:0] instr_q, pc_q, ea_q, data_q, ea_calc;
    logic [2:0]        cc_q, cc_new;
    logic              accept;

    lsag_decode u_dec (
        .opcode (instr[WORD_W-1:OP_LSB]),
        .ctl    (ctl_new)
    );

    lsag_agen #(.W(WORD_W), .PCOFF_W(PCOFF_W), .BOFF_W(BOFF_W)) u_agen (
        .off_field (instr_q[PCOFF_W-1:0]),
        .pc        (pc_q),
        .base      (rf_base_data),
        .base_mode (ctl_q.base_mode),
        .ea        (ea_calc)
    );

    lsag_cc #(.W(WORD_W)) u_cc (
        .value (data_q),
        .nzp   (cc_new)
    );

    assign accept      = (state_q == S_IDLE) && start && ctl_new.legal;
    assign rf_src_idx  = instr_q[OP_LSB-1:REG_LSB];
    assign rf_base_idx = instr_q[REG_LSB-1:BASE_LSB];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (accept) state_d = S_ADDR;
            S_ADDR: begin
                if (ctl_q.addr_only)     state_d = S_WRITEBACK;
                else if (ctl_q.indirect) state_d = S_IND_READ;
                else                     state_d = S_ACCESS;
            end
            S_IND_READ:  if (mem_ready) state_d = S_ACCESS;
            S_ACCESS: begin
                if (mem_ready) state_d = ctl_q.store ? S_DONE : S_WRITEBACK;
            end
            S_WRITEBACK: state_d = S_DONE;
            S_DONE:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_q <= '0;
            pc_q    <= '0;
            ea_q    <= '0;
            data_q  <= '0;
            ctl_q   <= '0;
            cc_q    <= 3'b010;
        end else begin
            if (accept) begin
                instr_q <= instr;
                pc_q    <= pc_next;
                ctl_q   <= ctl_new;
            end
            if (state_q == S_ADDR) begin
                ea_q <= ea_calc;
                if (ctl_q.addr_only) data_q <= ea_calc;
            end
            if (state_q == S_IND_READ && mem_ready) ea_q <= mem_rdata;
            if (state_q == S_ACCESS && mem_ready && !ctl_q.store) data_q <= mem_rdata;
            if (state_q == S_WRITEBACK) cc_q <= cc_new;
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ea_q;
        mem_wdata = '0;
        rf_we     = 1'b0;
        rf_waddr  = instr_q[OP_LSB-1:REG_LSB];
        rf_wdata  = data_q;
        busy      = 1'b1;
        done      = 1'b0;
        cc        = cc_q;
        unique case (state_q)
            S_IDLE:      busy = 1'b0;
            S_ADDR:      ;
            S_IND_READ:  mem_req = 1'b1;
            S_ACCESS: begin
                mem_req = 1'b1;
                if (ctl_q.store) begin
                    mem_we    = 1'b1;
                    mem_wdata = rf_src_data;
                end
            end
            S_WRITEBACK: rf_we = 1'b1;
            S_DONE:      done = 1'b1;
            default:     busy = 1'b0;
        endcase
    end

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_we_with_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    assert_addr_only_no_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_q.addr_only) |-> !mem_req);

    assert_store_no_rf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_q.store) |-> !rf_we);

    assert_cc_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc) == 1);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_legal_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ctl_q.legal);
endmodule

// File: tb/sim_lsag_seq.sv
module sim_lsag_seq;
    import lsag_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0, pc_next = '0;
    logic [2:0]  rf_src_idx, rf_base_idx, rf_waddr;
    logic [15:0] rf_src_data, rf_base_data, rf_wdata;
    logic        rf_we, mem_req, mem_we, busy, done;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic [2:0]  cc;

    logic [15:0] rf [8];
    int n_tests = 0, n_fail = 0;
    int rd_n = 0, wr_n = 0, rfw_n = 0, wait_n = 0, wcnt = 0, cyc = 0;
    logic [15:0] wr_addr, wr_data, last_rd;

    always #2 clk = ~clk;

    lsag_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_next(pc_next),
        .rf_src_idx(rf_src_idx), .rf_src_data(rf_src_data),
        .rf_base_idx(rf_base_idx), .rf_base_data(rf_base_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .cc(cc), .busy(busy), .done(done)
    );

    function automatic logic [15:0] mval(input logic [15:0] a);
        return {a[7:0], a[15:8]} + 16'h1357;
    endfunction
    function automatic logic [15:0] sx9(input logic [8:0] x);
        return {{7{x[8]}}, x};
    endfunction
    function automatic logic [15:0] sx6(input logic [5:0] x);
        return {{10{x[5]}}, x};
    endfunction
    function automatic logic [2:0] nzp(input logic [15:0] v);
        return v[15] ? 3'b100 : (v == 0 ? 3'b010 : 3'b001);
    endfunction

    assign rf_src_data  = rf[rf_src_idx];
    assign rf_base_data = rf[rf_base_idx];
    assign mem_rdata    = mval(mem_addr);

    always @(posedge clk) begin
        if (rf_we) begin
            rf[rf_waddr] <= rf_wdata;
            rfw_n++;
        end
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                wr_n++;
                wr_addr = mem_addr;
                wr_data = mem_wdata;
            end else begin
                rd_n++;
                last_rd = mem_addr;
            end
        end
    end

    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= wait_n) mem_ready = 1'b1;
            else wcnt++;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        rd_n = 0; wr_n = 0; rfw_n = 0;
    endtask

    task automatic run(input logic [15:0] ins, input logic [15:0] pc);
        clr();
        instr = ins; pc_next = pc; start = 1'b1; cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start = 1'b0;
        end while (!done && cyc < 200);
        if (!done) chk("R11 done seen", 16'd0, 16'd1);
        @(negedge clk);
        chk("R11 done one cycle", {15'd0, done}, 16'd0);
    endtask

    task automatic t_reset();
        chk("R1 mem_req", {15'd0, mem_req}, 0);
        chk("R1 rf_we", {15'd0, rf_we}, 0);
        chk("R1 busy/done", {14'd0, busy, done}, 0);
        chk("R1 cc", {13'd0, cc}, 16'h2);
    endtask

    task automatic t_load();
        logic [15:0] ea;
        ea = 16'h3001 + sx9(9'd5);
        run({OPC_LOAD, 3'd3, 9'd5}, 16'h3001);
        chk("R2 latency", 16'(cyc), 16'd4);
        chk("R2 reads", 16'(rd_n), 1);
        chk("R2 addr", last_rd, ea);
        chk("R2 dest", rf[3], mval(ea));
        chk("R8 cc load", {13'd0, cc}, {13'd0, nzp(mval(ea))});
        ea = 16'h3000 + sx9(9'h100);
        run({OPC_LOAD, 3'd4, 9'h100}, 16'h3000);
        chk("R2 negative offset", last_rd, ea);
        chk("R2 dest neg", rf[4], mval(ea));
    endtask

    task automatic t_store();
        logic [2:0] cc0;
        cc0 = cc;
        run({OPC_STORE, 3'd5, 9'h1F0}, 16'h4000);
        chk("R3 writes", 16'(wr_n), 1);
        chk("R3 addr", wr_addr, 16'h4000 + sx9(9'h1F0));
        chk("R3 data", wr_data, rf[5]);
        chk("R3 no rf write", 16'(rfw_n), 0);
        chk("R8 store keeps cc", {13'd0, cc}, {13'd0, cc0});
    endtask

    task automatic t_indirect();
        logic [15:0] ea, p;
        ea = 16'h5010 + sx9(9'd7);
        p = mval(ea);
        run({OPC_LOAD_I, 3'd1, 9'd7}, 16'h5010);
        chk("R4 reads", 16'(rd_n), 2);
        chk("R4 second addr", last_rd, p);
        chk("R4 dest", rf[1], mval(p));
        ea = 16'h6000 + sx9(9'h1FE);
        run({OPC_STORE_I, 3'd2, 9'h1FE}, 16'h6000);
        chk("R5 reads", 16'(rd_n), 1);
        chk("R5 writes", 16'(wr_n), 1);
        chk("R5 pointer addr", wr_addr, mval(ea));
        chk("R5 data", wr_data, rf[2]);
    endtask

    task automatic t_base();
        logic [15:0] ea;
        ea = rf[2] + sx6(6'h3F);
        run({OPC_LOAD_B, 3'd7, 3'd2, 6'h3F}, 16'h0100);
        chk("R6 load addr", last_rd, ea);
        chk("R6 load dest", rf[7], mval(ea));
        ea = rf[4] + sx6(6'd31);
        run({OPC_STORE_B, 3'd6, 3'd4, 6'd31}, 16'h0100);
        chk("R6 store addr", wr_addr, ea);
        chk("R6 store data", wr_data, rf[6]);
    endtask

    task automatic t_addr_only();
        run({OPC_ADDR, 3'd6, 9'h1FB}, 16'h0005);
        chk("R7 latency", 16'(cyc), 3);
        chk("R7 no memory", 16'(rd_n + wr_n), 0);
        chk("R7 dest", rf[6], 16'h0000);
        chk("R8 cc zero", {13'd0, cc}, 16'h2);
        run({OPC_ADDR, 3'd6, 9'd0}, 16'h8000);
        chk("R8 cc negative", {13'd0, cc}, 16'h4);
        run({OPC_ADDR, 3'd6, 9'd3}, 16'h0040);
        chk("R7 dest pos", rf[6], 16'h0043);
        chk("R8 cc positive", {13'd0, cc}, 16'h1);
    endtask

    task automatic t_wrap();
        run({OPC_LOAD, 3'd3, 9'h020}, 16'hFFF0);
        chk("R10 pc wrap", last_rd, 16'h0010);
        rf[1] = 16'hFFFF;
        run({OPC_LOAD_B, 3'd5, 3'd1, 6'd1}, 16'h0000);
        chk("R10 base wrap", last_rd, 16'h0000);
        chk("R10 base wrap data", rf[5], mval(16'h0000));
    endtask

    task automatic t_wait();
        logic [15:0] p;
        wait_n = 3;
        p = mval(16'h2000 + sx9(9'd1));
        run({OPC_LOAD_I, 3'd0, 9'd1}, 16'h2000);
        chk("R9 handshakes", 16'(rd_n), 2);
        chk("R9 dest", rf[0], mval(p));
        chk("R9 slow latency", {15'd0, cyc > 8}, 1);
        wait_n = 0;
    endtask

    task automatic t_ignore();
        logic [15:0] r6;
        int seen;
        clr();
        instr = 16'h1234; start = 1'b1; seen = 0;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (busy || done) seen++;
            @(negedge clk);
        end
        chk("R11 bad opcode ignored", 16'(seen + rd_n + wr_n + rfw_n), 0);
        wait_n = 4; r6 = rf[6]; clr(); seen = 0; cyc = 0;
        instr = {OPC_LOAD, 3'd1, 9'd2}; pc_next = 16'h0700; start = 1'b1;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start = 1'b0;
            if (cyc == 3) begin
                instr = {OPC_ADDR, 3'd6, 9'd9}; start = 1'b1;
            end
            if (cyc == 4) start = 1'b0;
        end while (!done && cyc < 200);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (done || busy) seen++;
        end
        chk("R11 busy start ignored", rf[6], r6);
        chk("R11 single write", 16'(rfw_n), 1);
        chk("R11 no second done", 16'(seen), 0);
        chk("R11 first result", rf[1], mval(16'h0702));
        wait_n = 0;
    endtask

    initial begin
        #400000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", n_tests);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = 16'h1111 * 16'(i) + 16'h0203;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_store();
        t_indirect();
        t_base();
        t_addr_only();
        t_wrap();
        t_wait();
        t_ignore();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule